// File: doc/BRIEF.md
# Descriptor-Driven Transmit DMA Engine

This block feeds an Ethernet transmitter from a packet buffer memory that is organised as a ring of descriptors. Software fills a descriptor and hands it to the engine by setting an ownership flag. On every tick of an external poll timer the engine checks the ownership flag of the descriptor it is parked on. Once the descriptor is owned, the engine reads the packet length, streams the packet bytes into the transmit FIFO and waits for the MAC to report that the frame has left. It then writes the MAC status back into the descriptor, which also hands ownership back to software, follows the link to the next descriptor and raises a one-cycle done pulse.

Each descriptor is seven bytes of header followed directly by the packet data. Bytes 0..2 hold the link to the next descriptor as a little-endian address. Bytes 3..4 hold the packet length, low byte first. Bytes 5..6 hold the status word, low byte first, and bit 7 of byte 6 is the ownership flag. The FIFO controller can ask for the current packet to be sent again (retry) or dropped (abort). In both cases the engine pulses a FIFO pointer reset and then waits for the controller to withdraw its request and acknowledge. After that it either restarts the packet from its first byte or closes the descriptor with an abort status.

The buffer memory has one port with a one-cycle read latency. A read issued in one cycle returns its data in the next cycle, and a write takes effect at the clock edge.

Top module: `tx_desc_dma`

## Requirements
- R1: After a synchronous active-low reset, the memory read, memory write, FIFO write, FIFO pointer reset and done outputs are all low. The descriptor pointer equals parameter RESET_PTR (default 0).
- R2: Each poll tick seen while idle causes exactly one memory read, at descriptor pointer + 6. If bit 7 of the returned byte is clear, the engine makes no further memory or FIFO access until the next tick.
- R3: When bit 7 is set, the engine reads the length from byte 3 (low) and byte 4 (high). It then writes exactly that many bytes to the FIFO, taken in ascending order from descriptor pointer + 7.
- R4: While the FIFO full input is high, no FIFO write occurs, and no byte is lost or repeated once full drops.
- R5: After the last byte, the engine waits for the transmit-done input. It then writes the status word {0, tx_stat[14:0]}, low byte to offset 5 and high byte to offset 6, so the ownership bit 7 of offset 6 reads back as 0.
- R6: After a completed packet, the engine reads offsets 0, 1 and 2 (least significant first) as the next descriptor pointer and raises done for exactly one cycle. The next poll reads at the new pointer + 6.
- R7: A retry request seen while streaming or waiting for completion produces a single-cycle FIFO pointer reset. After release, the engine resends the whole packet from its first byte with the full length.
- R8: An abort request produces a single-cycle FIFO pointer reset. After release, the engine writes status 16'h4000 to offsets 5..6, follows the next pointer and raises no done pulse.
- R9: After the pointer reset, no memory or FIFO access occurs until the acknowledge input is high while both retry and abort are low.
- R10: A packet of length 0 makes no FIFO write and goes straight to waiting for transmit-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_tick_i | input | 1 | Poll timer expiry, one-cycle pulse |
| mem_addr_o | output | ADDR_W | Buffer memory byte address |
| mem_rd_o | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_ptr_rst_o | output | 1 | Pulse clearing FIFO read and write pointers |
| retry_i | input | 1 | Retry request from FIFO controller |
| abort_i | input | 1 | Abort request from FIFO controller |
| ptr_rst_ack_i | input | 1 | FIFO controller pointer-reset acknowledge |
| tx_done_i | input | 1 | MAC transmission complete, status valid |
| tx_stat_i | input | 16 | MAC transmit status |
| done_irq_o | output | 1 | One-cycle packet-done pulse |

## Verification
The assertions assume three things about the surroundings. Once retry or abort is raised, it stays high until the engine has issued its pointer reset. The FIFO controller withdraws a request only together with, or before, raising acknowledge. The memory answers every read in the next cycle. The stimulus raises each request only at a negative edge one cycle after an observed FIFO write, and releases it only after the pointer-reset pulse has been seen. It drives acknowledge for a single cycle at the moment of release and pulses transmit-done only after the last expected byte has reached the FIFO. The memory model is a registered-read byte array, so read timing always matches what the engine expects.

// File: rtl/tdma_pkg.sv
// Package: shared types and descriptor layout for the transmit DMA engine.
// Assumes byte-addressed memory; all multi-byte descriptor fields little-endian.
package tdma_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_OWN_RQ, S_OWN_CK, S_LEN_RQ0, S_LEN_RQ1, S_LEN_CK,
        S_FETCH, S_LATCH, S_PUSH, S_WAIT, S_FLUSH, S_HOLD,
        S_ST_LO, S_ST_HI, S_NP_RQ0, S_NP_RQ1, S_NP_RQ2, S_NP_CK
    } tdma_state_e;

    typedef enum logic [3:0] {
        A_OWN, A_LEN_LO, A_LEN_HI, A_DATA, A_ST_LO, A_ST_HI, A_NP0, A_NP1, A_NP2
    } tdma_asel_e;

    localparam int unsigned OFS_NP0    = 0;
    localparam int unsigned OFS_NP1    = 1;
    localparam int unsigned OFS_NP2    = 2;
    localparam int unsigned OFS_LEN_LO = 3;
    localparam int unsigned OFS_LEN_HI = 4;
    localparam int unsigned OFS_ST_LO  = 5;
    localparam int unsigned OFS_ST_HI  = 6;
    localparam int unsigned OFS_DATA   = 7;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 2 * BYTE_W;
    localparam int unsigned STAT_W = 2 * BYTE_W;
    localparam int unsigned NP_W   = 3 * BYTE_W;

    localparam logic [STAT_W-1:0] ABORT_STATUS = 16'h4000;
    localparam logic [STAT_W-1:0] STAT_KEEP    = 16'h7FFF;

endpackage

// File: rtl/tdma_len_ctr.sv
// Module: packet length register and remaining-byte down-counter.
// Assumes the low length byte is captured the cycle before the high byte arrives.
module tdma_len_ctr
    import tdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic              lo_cap_i,
    input  logic              ld_i,
    input  logic              reload_i,
    input  logic              dec_i,
    output logic              cnt_last_o,
    output logic              ld_zero_o,
    output logic              len_zero_o
);

    logic [BYTE_W-1:0] lo_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_in;

    // Assemble the incoming length from the stored low byte and the current high byte.
    always_comb len_in = {rdata_i, lo_q};

    // Hold the packet length and count down the bytes still to be sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            len_q <= '0;
            cnt_q <= '0;
        end else begin
            if (lo_cap_i) lo_q <= rdata_i;
            if (ld_i) begin
                len_q <= len_in;
                cnt_q <= len_in;
            end else if (reload_i) begin
                cnt_q <= len_q;
            end else if (dec_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Flag the last byte, a zero incoming length and a zero stored length.
    always_comb begin
        cnt_last_o = (cnt_q == LEN_W'(1));
        ld_zero_o  = (len_in == '0);
        len_zero_o = (len_q == '0);
    end

    // R3: the byte counter never decrements past zero
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));

endmodule

// File: rtl/tdma_ptr_unit.sv
// Module: descriptor pointer, packet byte address and next-pointer assembly.
// Assumes the three next-pointer bytes are read in ascending order on consecutive cycles.
module tdma_ptr_unit
    import tdma_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 24,
    parameter logic [ADDR_W-1:0]    RESET_PTR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tdma_asel_e        asel_i,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic              addr_start_i,
    input  logic              addr_inc_i,
    input  logic              np_cap0_i,
    input  logic              np_cap1_i,
    input  logic              ptr_ld_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] cur_ptr_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] data_q;
    logic [BYTE_W-1:0] np0_q;
    logic [BYTE_W-1:0] np1_q;
    logic [NP_W-1:0]   np_full;

    // Join the captured link bytes with the byte now on the read bus.
    always_comb np_full = {rdata_i, np1_q, np0_q};

    // Track the descriptor pointer, the packet byte address and partial link bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= RESET_PTR;
            data_q <= '0;
            np0_q  <= '0;
            np1_q  <= '0;
        end else begin
            if (addr_start_i)    data_q <= ptr_q + ADDR_W'(OFS_DATA);
            else if (addr_inc_i) data_q <= data_q + 1'b1;
            if (np_cap0_i) np0_q <= rdata_i;
            if (np_cap1_i) np1_q <= rdata_i;
            if (ptr_ld_i)  ptr_q <= ADDR_W'(np_full);
        end
    end

    // Select the memory address for the access the controller requests.
    always_comb begin
        unique case (asel_i)
            A_OWN:    mem_addr_o = ptr_q + ADDR_W'(OFS_ST_HI);
            A_LEN_LO: mem_addr_o = ptr_q + ADDR_W'(OFS_LEN_LO);
            A_LEN_HI: mem_addr_o = ptr_q + ADDR_W'(OFS_LEN_HI);
            A_DATA:   mem_addr_o = data_q;
            A_ST_LO:  mem_addr_o = ptr_q + ADDR_W'(OFS_ST_LO);
            A_ST_HI:  mem_addr_o = ptr_q + ADDR_W'(OFS_ST_HI);
            A_NP0:    mem_addr_o = ptr_q + ADDR_W'(OFS_NP0);
            A_NP1:    mem_addr_o = ptr_q + ADDR_W'(OFS_NP1);
            A_NP2:    mem_addr_o = ptr_q + ADDR_W'(OFS_NP2);
            default:  mem_addr_o = ptr_q;
        endcase
    end

    assign cur_ptr_o = ptr_q;

endmodule

// File: rtl/tdma_fsm.sv
// Module: sequencing controller for polling, streaming, completion and recovery.
// Assumes registered-read memory (data one cycle after the read strobe) and that
// retry/abort stay asserted until the pointer reset has been issued.
module tdma_fsm
    import tdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_tick_i,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic              fifo_full_i,
    input  logic              retry_i,
    input  logic              abort_i,
    input  logic              ack_i,
    input  logic              tx_done_i,
    input  logic [STAT_W-1:0] tx_stat_i,
    input  logic              cnt_last_i,
    input  logic              ld_zero_i,
    input  logic              len_zero_i,
    output tdma_asel_e        asel_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              fifo_wr_o,
    output logic [BYTE_W-1:0] fifo_wdata_o,
    output logic              fifo_ptr_rst_o,
    output logic              done_irq_o,
    output logic              lo_cap_o,
    output logic              len_ld_o,
    output logic              len_reload_o,
    output logic              cnt_dec_o,
    output logic              addr_start_o,
    output logic              addr_inc_o,
    output logic              np_cap0_o,
    output logic              np_cap1_o,
    output logic              ptr_ld_o
);

    tdma_state_e       st_q, st_d;
    logic [STAT_W-1:0] stat_q;
    logic [BYTE_W-1:0] byte_q;
    logic              abort_q;
    logic              done_q;
    logic              req;

    // Any recovery request from the FIFO controller; abort takes precedence when latched.
    always_comb req = retry_i | abort_i;

    // Decode the next state and the per-cycle strobes from the current state.
    always_comb begin
        st_d         = st_q;
        asel_o       = A_OWN;
        mem_rd_o     = 1'b0;
        mem_wr_o     = 1'b0;
        mem_wdata_o  = '0;
        fifo_wr_o    = 1'b0;
        lo_cap_o     = 1'b0;
        len_ld_o     = 1'b0;
        len_reload_o = 1'b0;
        cnt_dec_o    = 1'b0;
        addr_start_o = 1'b0;
        addr_inc_o   = 1'b0;
        np_cap0_o    = 1'b0;
        np_cap1_o    = 1'b0;
        ptr_ld_o     = 1'b0;
        unique case (st_q)
            S_IDLE:    if (poll_tick_i) st_d = S_OWN_RQ;
            S_OWN_RQ: begin
                asel_o   = A_OWN;
                mem_rd_o = 1'b1;
                st_d     = S_OWN_CK;
            end
            S_OWN_CK:  st_d = rdata_i[7] ? S_LEN_RQ0 : S_IDLE;
            S_LEN_RQ0: begin
                asel_o   = A_LEN_LO;
                mem_rd_o = 1'b1;
                st_d     = S_LEN_RQ1;
            end
            S_LEN_RQ1: begin
                lo_cap_o = 1'b1;
                asel_o   = A_LEN_HI;
                mem_rd_o = 1'b1;
                st_d     = S_LEN_CK;
            end
            S_LEN_CK: begin
                len_ld_o     = 1'b1;
                addr_start_o = 1'b1;
                st_d         = ld_zero_i ? S_WAIT : S_FETCH;
            end
            S_FETCH: begin
                if (req) begin
                    st_d = S_FLUSH;
                end else begin
                    asel_o   = A_DATA;
                    mem_rd_o = 1'b1;
                    st_d     = S_LATCH;
                end
            end
            S_LATCH:   st_d = req ? S_FLUSH : S_PUSH;
            S_PUSH: begin
                if (req) begin
                    st_d = S_FLUSH;
                end else if (!fifo_full_i) begin
                    fifo_wr_o  = 1'b1;
                    cnt_dec_o  = 1'b1;
                    addr_inc_o = 1'b1;
                    st_d       = cnt_last_i ? S_WAIT : S_FETCH;
                end
            end
            S_WAIT: begin
                if (req)            st_d = S_FLUSH;
                else if (tx_done_i) st_d = S_ST_LO;
            end
            S_FLUSH:   st_d = S_HOLD;
            S_HOLD: begin
                if (ack_i && !req) begin
                    if (abort_q) begin
                        st_d = S_ST_LO;
                    end else begin
                        len_reload_o = 1'b1;
                        addr_start_o = 1'b1;
                        st_d         = len_zero_i ? S_WAIT : S_FETCH;
                    end
                end
            end
            S_ST_LO: begin
                asel_o      = A_ST_LO;
                mem_wr_o    = 1'b1;
                mem_wdata_o = stat_q[BYTE_W-1:0];
                st_d        = S_ST_HI;
            end
            S_ST_HI: begin
                asel_o      = A_ST_HI;
                mem_wr_o    = 1'b1;
                mem_wdata_o = stat_q[STAT_W-1:BYTE_W];
                st_d        = S_NP_RQ0;
            end
            S_NP_RQ0: begin
                asel_o   = A_NP0;
                mem_rd_o = 1'b1;
                st_d     = S_NP_RQ1;
            end
            S_NP_RQ1: begin
                np_cap0_o = 1'b1;
                asel_o    = A_NP1;
                mem_rd_o  = 1'b1;
                st_d      = S_NP_RQ2;
            end
            S_NP_RQ2: begin
                np_cap1_o = 1'b1;
                asel_o    = A_NP2;
                mem_rd_o  = 1'b1;
                st_d      = S_NP_CK;
            end
            S_NP_CK: begin
                ptr_ld_o = 1'b1;
                st_d     = S_IDLE;
            end
            default:   st_d = S_IDLE;
        endcase
    end

    // Advance the state and hold status, the fetched byte, the recovery kind and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            stat_q  <= '0;
            byte_q  <= '0;
            abort_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == S_NP_CK) && !abort_q;
            if (st_q == S_LATCH) byte_q <= rdata_i;
            if (st_d == S_FLUSH) abort_q <= abort_i;
            if (st_q == S_WAIT && !req && tx_done_i) begin
                stat_q  <= tx_stat_i & STAT_KEEP;
                abort_q <= 1'b0;
            end
            if (st_q == S_HOLD && ack_i && !req && abort_q) stat_q <= ABORT_STATUS;
        end
    end

    assign fifo_wdata_o   = byte_q;
    assign fifo_ptr_rst_o = (st_q == S_FLUSH);
    assign done_irq_o     = done_q;

    // R7: the FIFO pointer reset lasts a single cycle
    a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ptr_rst_o |=> !fifo_ptr_rst_o);

    // R9: the engine stays parked while a request is still raised
    a_r9_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HOLD && req) |=> (st_q == S_HOLD));

    // R6: the done indication is a one-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o);

    // R4: no FIFO write is issued in the cycle after a stall with full still high
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PUSH && fifo_full_i && !req) |=> (st_q == S_PUSH));

endmodule

// File: rtl/tx_desc_dma.sv
// Module: top level of the descriptor-based transmit DMA engine.
// Assumes a single-port byte memory with one-cycle read latency and a FIFO
// controller that releases retry/abort together with its acknowledge.
module tx_desc_dma
    import tdma_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] RESET_PTR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_tick_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              fifo_wr_o,
    output logic [7:0]        fifo_wdata_o,
    input  logic              fifo_full_i,
    output logic              fifo_ptr_rst_o,
    input  logic              retry_i,
    input  logic              abort_i,
    input  logic              ptr_rst_ack_i,
    input  logic              tx_done_i,
    input  logic [15:0]       tx_stat_i,
    output logic              done_irq_o
);

    tdma_asel_e        asel;
    logic              lo_cap, len_ld, len_reload, cnt_dec;
    logic              addr_start, addr_inc, np_cap0, np_cap1, ptr_ld;
    logic              cnt_last, ld_zero, len_zero;
    logic [ADDR_W-1:0] cur_ptr;

    tdma_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .poll_tick_i    (poll_tick_i),
        .rdata_i        (mem_rdata_i),
        .fifo_full_i    (fifo_full_i),
        .retry_i        (retry_i),
        .abort_i        (abort_i),
        .ack_i          (ptr_rst_ack_i),
        .tx_done_i      (tx_done_i),
        .tx_stat_i      (tx_stat_i),
        .cnt_last_i     (cnt_last),
        .ld_zero_i      (ld_zero),
        .len_zero_i     (len_zero),
        .asel_o         (asel),
        .mem_rd_o       (mem_rd_o),
        .mem_wr_o       (mem_wr_o),
        .mem_wdata_o    (mem_wdata_o),
        .fifo_wr_o      (fifo_wr_o),
        .fifo_wdata_o   (fifo_wdata_o),
        .fifo_ptr_rst_o (fifo_ptr_rst_o),
        .done_irq_o     (done_irq_o),
        .lo_cap_o       (lo_cap),
        .len_ld_o       (len_ld),
        .len_reload_o   (len_reload),
        .cnt_dec_o      (cnt_dec),
        .addr_start_o   (addr_start),
        .addr_inc_o     (addr_inc),
        .np_cap0_o      (np_cap0),
        .np_cap1_o      (np_cap1),
        .ptr_ld_o       (ptr_ld)
    );

    tdma_len_ctr u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdata_i    (mem_rdata_i),
        .lo_cap_i   (lo_cap),
        .ld_i       (len_ld),
        .reload_i   (len_reload),
        .dec_i      (cnt_dec),
        .cnt_last_o (cnt_last),
        .ld_zero_o  (ld_zero),
        .len_zero_o (len_zero)
    );

    tdma_ptr_unit #(
        .ADDR_W    (ADDR_W),
        .RESET_PTR (RESET_PTR)
    ) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .asel_i       (asel),
        .rdata_i      (mem_rdata_i),
        .addr_start_i (addr_start),
        .addr_inc_i   (addr_inc),
        .np_cap0_i    (np_cap0),
        .np_cap1_i    (np_cap1),
        .ptr_ld_i     (ptr_ld),
        .mem_addr_o   (mem_addr_o),
        .cur_ptr_o    (cur_ptr)
    );

    // R5: every write of the status high byte hands ownership back
    a_r5_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_addr_o == cur_ptr + ADDR_W'(OFS_ST_HI)) |-> !mem_wdata_o[7]);

    // R2: the single memory port is never asked to read and write at once
    a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

endmodule

// File: tb/test_tx_desc_dma.sv
// Bench: scoreboard driver/monitor for the transmit DMA engine.
module test_tx_desc_dma;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          poll_tick = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          fifo_wr;
    logic [7:0]    fifo_wdata;
    logic          fifo_full = 1'b0;
    logic          fifo_ptr_rst;
    logic          retry = 1'b0, abort_r = 1'b0, ack = 1'b0;
    logic          tx_done = 1'b0;
    logic [15:0]   tx_stat = '0;
    logic          done_irq;

    logic [7:0]    mem [0:1023];
    logic [7:0]    exp_q[$];
    int            rd_log[$];
    int            n_checks = 0, n_fail = 0;
    int            wr_cnt = 0, rst_cnt = 0, done_cnt = 0, memwr_cnt = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    tx_desc_dma #(.ADDR_W(AW)) i_tx_desc_dma (
        .clk(clk), .rst_n(rst_n), .poll_tick_i(poll_tick),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata), .fifo_full_i(fifo_full),
        .fifo_ptr_rst_o(fifo_ptr_rst), .retry_i(retry), .abort_i(abort_r),
        .ptr_rst_ack_i(ack), .tx_done_i(tx_done), .tx_stat_i(tx_stat),
        .done_irq_o(done_irq)
    );

    // Registered-read byte memory.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every FIFO write and tallies events.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr) begin
                wr_cnt++;
                if (fifo_full) check(1'b0, "R4 write while full", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected FIFO byte", int'(fifo_wdata), -1);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    check(fifo_wdata == e, "R3 FIFO byte order", int'(fifo_wdata), int'(e));
                end
            end
            if (fifo_ptr_rst) rst_cnt++;
            if (done_irq) done_cnt++;
            if (mem_wr) memwr_cnt++;
            if (mem_rd) rd_log.push_back(int'(mem_addr));
        end
    end

    // Driver: builds a descriptor and pushes its data bytes into the scoreboard.
    task automatic set_desc(input int base, input int nxt, input int len,
                            input bit own, input logic [7:0] first);
        mem[base+0] = nxt[7:0];
        mem[base+1] = nxt[15:8];
        mem[base+2] = nxt[23:16];
        mem[base+3] = len[7:0];
        mem[base+4] = len[15:8];
        mem[base+5] = 8'h00;
        mem[base+6] = {own, 7'h00};
        for (int i = 0; i < len; i++) mem[base+7+i] = first + 8'(i);
    endtask

    task automatic push_exp(input logic [7:0] first, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(first + 8'(i));
    endtask

    task automatic tick();
        @(negedge clk) poll_tick = 1'b1;
        @(negedge clk) poll_tick = 1'b0;
    endtask

    task automatic finish_tx(input logic [15:0] s);
        repeat (3) @(negedge clk);
        tx_done = 1'b1; tx_stat = s;
        @(negedge clk) tx_done = 1'b0;
    endtask

    task automatic release_req();
        @(negedge clk) begin retry = 1'b0; abort_r = 1'b0; ack = 1'b1; end
        @(negedge clk) ack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int b, r0, d0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        set_desc(24'h000, 24'h040, 5, 1'b0, 8'h11);
        set_desc(24'h040, 24'h080, 4, 1'b1, 8'h21);
        set_desc(24'h080, 24'h0C0, 6, 1'b1, 8'h31);
        set_desc(24'h0C0, 24'h000, 0, 1'b1, 8'h00);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!mem_rd && !mem_wr && !fifo_wr && !fifo_ptr_rst && !done_irq,
              "R1 outputs idle after reset",
              {mem_rd, mem_wr, fifo_wr, fifo_ptr_rst, done_irq}, 0);

        // R2: polling a descriptor not owned by the engine
        for (int k = 0; k < 3; k++) begin
            tick();
            repeat (5) @(negedge clk);
        end
        check(rd_log.size() == 3, "R2 one read per tick", rd_log.size(), 3);
        check(rd_log[0] == 6, "R1 R2 first poll at reset pointer+6", rd_log[0], 6);
        check(wr_cnt == 0 && memwr_cnt == 0, "R2 no access when not owned",
              wr_cnt + memwr_cnt, 0);

        // R3 R4 R5 R6: plain packet with a FIFO stall
        mem[6] = 8'h80;
        push_exp(8'h11, 5);
        tick();
        wait (wr_cnt == 2);
        @(negedge clk) fifo_full = 1'b1;
        b = wr_cnt;
        repeat (8) @(negedge clk);
        check(wr_cnt == b, "R4 no write while full", wr_cnt, b);
        fifo_full = 1'b0;
        wait (wr_cnt == 5);
        finish_tx(16'hA5C3);
        wait (done_cnt == 1);
        @(negedge clk);
        check(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
        check(mem[5] == 8'hC3, "R5 status low byte", mem[5], 8'hC3);
        check(mem[6] == 8'h25, "R5 status high byte, owner cleared", mem[6], 8'h25);
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R6 single done pulse", done_cnt, 1);

        // R6 R7 R9: next descriptor, retry after two bytes
        rd_log.delete();
        r0 = rst_cnt;
        push_exp(8'h21, 2);
        push_exp(8'h21, 4);
        tick();
        @(negedge clk);
        check(rd_log[0] == 24'h046, "R6 poll follows next pointer", rd_log[0], 24'h046);
        wait (wr_cnt == 7);
        @(negedge clk) retry = 1'b1;
        wait (rst_cnt == r0 + 1);
        b = wr_cnt;
        d0 = memwr_cnt;
        rd_log.delete();
        repeat (4) @(negedge clk);
        check(wr_cnt == b && memwr_cnt == d0 && rd_log.size() == 0,
              "R9 parked while retry held", wr_cnt - b + rd_log.size(), 0);
        release_req();
        wait (wr_cnt == 11);
        check(rst_cnt == r0 + 1, "R7 one pointer reset", rst_cnt, r0 + 1);
        finish_tx(16'h0012);
        wait (done_cnt == 2);
        @(negedge clk);
        check(exp_q.size() == 0, "R7 full packet resent", exp_q.size(), 0);
        check(mem[24'h045] == 8'h12 && mem[24'h046] == 8'h00, "R5 retry packet status",
              {mem[24'h046], mem[24'h045]}, 16'h0012);

        // R8: abort after three bytes
        r0 = rst_cnt;
        d0 = done_cnt;
        push_exp(8'h31, 3);
        tick();
        wait (wr_cnt == 14);
        @(negedge clk) abort_r = 1'b1;
        wait (rst_cnt == r0 + 1);
        repeat (2) @(negedge clk);
        release_req();
        repeat (15) @(negedge clk);
        check(exp_q.size() == 0 && wr_cnt == 14, "R8 no bytes after abort", wr_cnt, 14);
        check(mem[24'h085] == 8'h00 && mem[24'h086] == 8'h40, "R8 abort status",
              {mem[24'h086], mem[24'h085]}, 16'h4000);
        check(done_cnt == d0, "R8 no done pulse on abort", done_cnt, d0);

        // R10: zero-length packet at the descriptor after the aborted one
        rd_log.delete();
        tick();
        @(negedge clk);
        check(rd_log[0] == 24'h0C6, "R8 advanced past aborted packet", rd_log[0], 24'h0C6);
        repeat (10) @(negedge clk);
        check(wr_cnt == 14, "R10 no FIFO write for zero length", wr_cnt, 14);
        finish_tx(16'h8001);
        wait (done_cnt == d0 + 1);
        @(negedge clk);
        check(mem[24'h0C5] == 8'h01 && mem[24'h0C6] == 8'h00, "R10 R5 status written",
              {mem[24'h0C6], mem[24'h0C5]}, 16'h0001);

        // R6: ring wraps to the first descriptor, now owned by software
        rd_log.delete();
        b = memwr_cnt;
        tick();
        repeat (6) @(negedge clk);
        check(rd_log.size() == 1 && rd_log[0] == 6, "R6 R2 wrap poll only", rd_log[0], 6);
        check(memwr_cnt == b && wr_cnt == 14, "R2 idle after wrap", memwr_cnt - b, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule